// File: doc/BRIEF.md
# Bordered Sliding-Window Generator

This block takes a raster stream of single-plane pixels and, for every pixel it accepts, delivers the square neighbourhood of side K centred on that pixel. K is 3, 5 or 7 and is fixed when the block is built. The frame width and height are also build-time parameters. Recent rows are kept in a small circular row store. When the centre lies near a border, part of the window falls outside the frame. Those taps are filled according to one of three policies: a constant fill value, replication of the nearest in-frame pixel, or reflection about the border line with the border pixel itself not repeated.

Pixels enter through a valid/ready handshake, and a start-of-frame marker comes with the first pixel of each frame. The source may stream without pause or leave idle cycles between pixels. The window output runs at a fixed distance behind the input: R rows plus R pixels, where R = (K-1)/2, plus two register stages. After the last pixel of a frame is accepted, the block lowers ready. It then produces the remaining bottom-row windows on its own, one per cycle, and raises ready again once the frame is finished. A downstream sorting or filtering stage consumes the window array.

Top module: `pixwin_gen`

## Requirements
- R1: `win_o` carries K*K taps of DW bits. The tap at window row i and column j (0 = top/left) sits at bits [(i*K+j)*DW +: DW]. It holds the pixel at frame row r+i-R and column c+j-R for centre (r,c), where R=(K-1)/2, whenever that position lies inside the frame.
- R2: A pixel is accepted on a rising clock edge when `pix_valid_i`, `ready_o` and `ce` are all high. Data offered while `ready_o` is low is ignored, even if it carries a start-of-frame marker.
- R3: An accepted pixel with `pix_sof_i` high is taken as row 0, column 0 of a new frame. This holds whatever pixels were accepted before it.
- R4: Each frame yields exactly IMG_W*IMG_H windows, in raster order of their centres. `win_sof_o` is high only with the window centred at (0,0), and only while `win_valid_o` is high.
- R5: Fill policy (EDGE_FILL, encoding 0): every tap whose row or column lies outside the frame equals FILL_VAL.
- R6: Replicate policy (EDGE_COPY, encoding 1): an out-of-frame row or column index is clamped to 0 or to the last index.
- R7: Reflect policy (EDGE_MIRROR, encoding 2): an index -d maps to d, and an index n-1+d maps to n-1-d. So -1 maps to 1 and the border is not repeated.
- R8: The window centred on linear position p is registered two clock-enabled cycles after the step that produces it. For p < N-L, with L = R*IMG_W+R, that step is the acceptance of pixel p+L. Otherwise the step is the (p+L-N+1)-th clock-enabled cycle after the frame's last pixel, one window per cycle.
- R9: `ready_o` is low while the end-of-frame windows are being produced, and whenever `ce` is low.
- R10: While `ce` is low, no state changes and the outputs hold their values.
- R11: `srst` high at a clock edge returns the block to idle: no valid window, and ready following `ce`. `rst_n` low does the same asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable, active high |
| pix_valid_i | input | 1 | Input pixel present |
| pix_sof_i | input | 1 | Input pixel is row 0, column 0 |
| pix_data_i | input | DW | Input pixel value |
| ready_o | output | 1 | Block can accept a pixel this cycle |
| win_valid_o | output | 1 | `win_o` holds a new window |
| win_sof_o | output | 1 | Window is centred on row 0, column 0 |
| win_o | output | K*K*DW | Window taps, row-major |

## Verification
The risky coincidence is a pixel write into the circular row store landing in the same cycle as the output stage reads a window. This happens when the write goes to the slot that still holds the oldest row of that window, or to a column next to its taps. Unbroken input bursts and randomly gapped input both produce this, on small frames in all three border policies with K of 3 and 5. Each window is compared tap for tap with an arithmetic model of the frame. A second overlap puts clock-enable drops on the same cycles as flush steps and pixel steps. Each window's arrival is timed in clock-enabled cycles against the acceptance record, which judges that overlap.

// File: rtl/pixwin_pkg.sv
package pixwin_pkg;

    typedef enum logic [1:0] {
        EDGE_FILL   = 2'd0,
        EDGE_COPY   = 2'd1,
        EDGE_MIRROR = 2'd2
    } edge_e;

    // Maps a possibly out-of-frame index onto a stored index; -1 requests the fill value.
    function automatic int fold_idx(input int p, input int n, input edge_e m);
        if (p >= 0 && p < n) return p;
        if (m == EDGE_FILL) return -1;
        if (m == EDGE_COPY) return (p < 0) ? 0 : n - 1;
        return (p < 0) ? -p : 2 * (n - 1) - p;
    endfunction

endpackage

// File: rtl/pixwin_seq.sv
module pixwin_seq #(
    parameter int IMG_W = 320,
    parameter int IMG_H = 240,
    parameter int K     = 3,
    parameter int RW    = $clog2(IMG_H),
    parameter int CW    = $clog2(IMG_W),
    parameter int SW    = $clog2(K)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst,
    input  logic          ce,
    input  logic          vin,
    input  logic          sof,
    output logic          ready_o,
    output logic          wr_en_o,
    output logic [SW-1:0] wr_slot_o,
    output logic [CW-1:0] wr_col_o,
    output logic          st_vld_o,
    output logic [RW-1:0] st_row_o,
    output logic [CW-1:0] st_col_o,
    output logic [SW-1:0] st_slot_o
);
    localparam int R = (K - 1) / 2;

    typedef struct packed {
        logic [RW-1:0] irow;
        logic [CW-1:0] icol;
        logic [SW-1:0] islot;
        logic [RW-1:0] orow;
        logic [CW-1:0] ocol;
        logic [SW-1:0] oslot;
        logic          flush;
        logic          svld;
        logic [RW-1:0] srow;
        logic [CW-1:0] scol;
        logic [SW-1:0] sslot;
    } seq_t;

    seq_t seq_d, seq_q;
    logic          acc, step, lastin;
    logic [RW-1:0] pr, cr;
    logic [CW-1:0] pc, cc;
    logic [SW-1:0] ps, cs;

    always_comb begin
        seq_d  = seq_q;
        pr     = seq_q.irow;
        pc     = seq_q.icol;
        ps     = seq_q.islot;
        cr     = seq_q.orow;
        cc     = seq_q.ocol;
        cs     = seq_q.oslot;
        acc    = 1'b0;
        step   = 1'b0;
        lastin = 1'b0;
        if (srst) begin
            seq_d = '0;
        end else if (ce) begin
            seq_d.svld = 1'b0;
            acc = vin && !seq_q.flush;
            if (acc) begin
                if (sof) begin
                    pr = '0; pc = '0; ps = '0;
                    cr = '0; cc = '0; cs = '0;
                end
                step   = (pr > RW'(R)) || (pr == RW'(R) && pc >= CW'(R));
                lastin = (pr == RW'(IMG_H - 1)) && (pc == CW'(IMG_W - 1));
                seq_d.irow  = pr;
                seq_d.islot = ps;
                if (pc == CW'(IMG_W - 1)) begin
                    seq_d.icol = '0;
                    if (lastin) begin
                        seq_d.irow  = '0;
                        seq_d.islot = '0;
                    end else begin
                        seq_d.irow  = pr + 1'b1;
                        seq_d.islot = (ps == SW'(K - 1)) ? '0 : ps + 1'b1;
                    end
                end else begin
                    seq_d.icol = pc + 1'b1;
                end
                seq_d.flush = lastin;
            end else if (seq_q.flush) begin
                step = 1'b1;
                if (cr == RW'(IMG_H - 1) && cc == CW'(IMG_W - 1)) seq_d.flush = 1'b0;
            end
            seq_d.orow  = cr;
            seq_d.ocol  = cc;
            seq_d.oslot = cs;
            if (step) begin
                seq_d.svld  = 1'b1;
                seq_d.srow  = cr;
                seq_d.scol  = cc;
                seq_d.sslot = cs;
                if (cc == CW'(IMG_W - 1)) begin
                    seq_d.ocol = '0;
                    if (cr == RW'(IMG_H - 1)) begin
                        seq_d.orow  = '0;
                        seq_d.oslot = '0;
                    end else begin
                        seq_d.orow  = cr + 1'b1;
                        seq_d.oslot = (cs == SW'(K - 1)) ? '0 : cs + 1'b1;
                    end
                end else begin
                    seq_d.ocol = cc + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign ready_o   = ce && !seq_q.flush;
    assign wr_en_o   = acc;
    assign wr_slot_o = ps;
    assign wr_col_o  = pc;
    assign st_vld_o  = seq_q.svld;
    assign st_row_o  = seq_q.srow;
    assign st_col_o  = seq_q.scol;
    assign st_slot_o = seq_q.sslot;

endmodule

// File: rtl/pixwin_edge.sv
module pixwin_edge #(
    parameter int                IMG_W = 320,
    parameter int                IMG_H = 240,
    parameter int                K     = 3,
    parameter pixwin_pkg::edge_e EDGE  = pixwin_pkg::EDGE_FILL,
    parameter int                RW    = $clog2(IMG_H),
    parameter int                CW    = $clog2(IMG_W),
    parameter int                SW    = $clog2(K)
) (
    input  logic [RW-1:0]     row,
    input  logic [CW-1:0]     col,
    input  logic [SW-1:0]     slot,
    output logic [K*K*SW-1:0] tslot,
    output logic [K*K*CW-1:0] tcol,
    output logic [K*K-1:0]    tfill
);
    localparam int R = (K - 1) / 2;

    always_comb begin
        int yy, xx, s, t;
        tslot = '0;
        tcol  = '0;
        tfill = '0;
        for (int i = 0; i < K; i++) begin
            for (int j = 0; j < K; j++) begin
                t  = i * K + j;
                yy = pixwin_pkg::fold_idx(int'(row) + i - R, IMG_H, EDGE);
                xx = pixwin_pkg::fold_idx(int'(col) + j - R, IMG_W, EDGE);
                tfill[t] = (yy < 0) || (xx < 0);
                if (yy < 0) yy = int'(row);
                if (xx < 0) xx = int'(col);
                // rows row-R..row+R occupy consecutive slots modulo K
                s = (int'(slot) + (yy - int'(row)) + K) % K;
                tslot[t*SW +: SW] = SW'(s);
                tcol[t*CW +: CW]  = CW'(xx);
            end
        end
    end

endmodule

// File: rtl/pixwin_store.sv
module pixwin_store #(
    parameter int IMG_W = 320,
    parameter int K     = 3,
    parameter int DW    = 8,
    parameter int CW    = $clog2(IMG_W),
    parameter int SW    = $clog2(K)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [SW-1:0]     wslot,
    input  logic [CW-1:0]     wcol,
    input  logic [DW-1:0]     wdata,
    input  logic [K*K*SW-1:0] rslot,
    input  logic [K*K*CW-1:0] rcol,
    output logic [K*K*DW-1:0] rdata
);
    logic [DW-1:0] mem_q [K][IMG_W];

    always_ff @(posedge clk) begin
        if (we) mem_q[wslot][wcol] <= wdata;
    end

    for (genvar t = 0; t < K * K; t++) begin : g_tap
        assign rdata[t*DW +: DW] = mem_q[rslot[t*SW +: SW]][rcol[t*CW +: CW]];
    end

endmodule

// File: rtl/pixwin_gen.sv
module pixwin_gen #(
    parameter int                K        = 3,
    parameter int                IMG_W    = 320,
    parameter int                IMG_H    = 240,
    parameter int                DW       = 8,
    parameter pixwin_pkg::edge_e EDGE     = pixwin_pkg::EDGE_FILL,
    parameter int                FILL_VAL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              ce,
    input  logic              pix_valid_i,
    input  logic              pix_sof_i,
    input  logic [DW-1:0]     pix_data_i,
    output logic              ready_o,
    output logic              win_valid_o,
    output logic              win_sof_o,
    output logic [K*K*DW-1:0] win_o
);
    localparam int TAPS = K * K;
    localparam int RW   = $clog2(IMG_H);
    localparam int CW   = $clog2(IMG_W);
    localparam int SW   = $clog2(K);

    typedef struct packed {
        logic                 vld;
        logic                 sof;
        logic [TAPS*DW-1:0]   win;
    } out_t;

    logic                 wr_en, st_vld;
    logic [SW-1:0]        wr_slot, st_slot;
    logic [CW-1:0]        wr_col, st_col;
    logic [RW-1:0]        st_row;
    logic [TAPS*SW-1:0]   tslot;
    logic [TAPS*CW-1:0]   tcol;
    logic [TAPS-1:0]      tfill;
    logic [TAPS*DW-1:0]   raw;
    out_t                 out_d, out_q;

    pixwin_seq #(.IMG_W(IMG_W), .IMG_H(IMG_H), .K(K), .RW(RW), .CW(CW), .SW(SW)) u_seq (
        .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce),
        .vin(pix_valid_i), .sof(pix_sof_i), .ready_o(ready_o),
        .wr_en_o(wr_en), .wr_slot_o(wr_slot), .wr_col_o(wr_col),
        .st_vld_o(st_vld), .st_row_o(st_row), .st_col_o(st_col), .st_slot_o(st_slot)
    );

    pixwin_edge #(.IMG_W(IMG_W), .IMG_H(IMG_H), .K(K), .EDGE(EDGE), .RW(RW), .CW(CW), .SW(SW)) u_edge (
        .row(st_row), .col(st_col), .slot(st_slot),
        .tslot(tslot), .tcol(tcol), .tfill(tfill)
    );

    pixwin_store #(.IMG_W(IMG_W), .K(K), .DW(DW), .CW(CW), .SW(SW)) u_store (
        .clk(clk), .we(wr_en), .wslot(wr_slot), .wcol(wr_col), .wdata(pix_data_i),
        .rslot(tslot), .rcol(tcol), .rdata(raw)
    );

    always_comb begin
        out_d = out_q;
        if (srst) begin
            out_d = '0;
        end else if (ce) begin
            out_d.vld = st_vld;
            out_d.sof = st_vld && (st_row == '0) && (st_col == '0);
            if (st_vld) begin
                for (int t = 0; t < TAPS; t++) begin
                    out_d.win[t*DW +: DW] = tfill[t] ? DW'(FILL_VAL) : raw[t*DW +: DW];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign win_valid_o = out_q.vld;
    assign win_sof_o   = out_q.sof;
    assign win_o       = out_q.win;

endmodule

// File: rtl/pixwin_chk.sv
module pixwin_chk #(
    parameter int K  = 3,
    parameter int DW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              srst,
    input logic              ce,
    input logic              ready_o,
    input logic              win_valid_o,
    input logic              win_sof_o,
    input logic [K*K*DW-1:0] win_o
);
    assert_sof_has_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        win_sof_o |-> win_valid_o);

    assert_flush_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !ready_o && !srst) ##1 (ce && !srst) |=> win_valid_o);

    assert_ce_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !srst) |=> ($stable(win_o) && $stable(win_valid_o) && $stable(win_sof_o)));

    assert_srst_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!win_valid_o && !win_sof_o && (ready_o == ce)));

endmodule

bind pixwin_gen pixwin_chk #(.K(K), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce), .ready_o(ready_o),
    .win_valid_o(win_valid_o), .win_sof_o(win_sof_o), .win_o(win_o)
);

// File: tb/tb_pixwin_gen.sv
`timescale 1ns/1ps
module tb_pixwin_gen;
    localparam int W = 8;
    localparam int H = 7;
    localparam int N = W * H;
    localparam logic [7:0] FILLV = 8'hA5;

    logic clk = 1'b0;
    logic rst_n, srst, ce, vin, sof;
    logic [7:0] din;
    logic [3:0] rdy, vo, so;
    logic [71:0]  w0, w1, w2;
    logic [199:0] w3;

    int checks = 0, errors = 0, ccnt = 0;
    logic lce = 1'b0;
    bit mon_en = 1'b1;
    logic [7:0] img [3][H][W];
    int acc_t [3][N];
    int ocnt [4];
    int ofr  [4];

    always #4 clk = ~clk;

    pixwin_gen #(.K(3), .IMG_W(W), .IMG_H(H), .DW(8), .EDGE(pixwin_pkg::EDGE_FILL), .FILL_VAL(165)) dut (
        .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce), .pix_valid_i(vin), .pix_sof_i(sof),
        .pix_data_i(din), .ready_o(rdy[0]), .win_valid_o(vo[0]), .win_sof_o(so[0]), .win_o(w0));
    pixwin_gen #(.K(3), .IMG_W(W), .IMG_H(H), .DW(8), .EDGE(pixwin_pkg::EDGE_COPY), .FILL_VAL(0)) dut_cp (
        .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce), .pix_valid_i(vin), .pix_sof_i(sof),
        .pix_data_i(din), .ready_o(rdy[1]), .win_valid_o(vo[1]), .win_sof_o(so[1]), .win_o(w1));
    pixwin_gen #(.K(3), .IMG_W(W), .IMG_H(H), .DW(8), .EDGE(pixwin_pkg::EDGE_MIRROR), .FILL_VAL(0)) dut_mr (
        .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce), .pix_valid_i(vin), .pix_sof_i(sof),
        .pix_data_i(din), .ready_o(rdy[2]), .win_valid_o(vo[2]), .win_sof_o(so[2]), .win_o(w2));
    pixwin_gen #(.K(5), .IMG_W(W), .IMG_H(H), .DW(8), .EDGE(pixwin_pkg::EDGE_MIRROR), .FILL_VAL(0)) dut_k5 (
        .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce), .pix_valid_i(vin), .pix_sof_i(sof),
        .pix_data_i(din), .ready_o(rdy[3]), .win_valid_o(vo[3]), .win_sof_o(so[3]), .win_o(w3));

    task automatic chk(input string req, input logic [199:0] got, input logic [199:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int bfold(input int p, input int n, input int m);
        if (p >= 0 && p < n) return p;
        if (m == 0) return -1;
        if (m == 1) return (p < 0) ? 0 : n - 1;
        return (p < 0) ? -p : 2 * (n - 1) - p;
    endfunction

    task automatic obs(input int id, input int k, input int m, input logic v, input logic s,
                       input logic [199:0] w);
        int p, f, r, c, rr, lag, stp, y, x;
        logic [199:0] e;
        if (!v) return;
        p = ocnt[id];
        f = ofr[id];
        if (f > 2) begin
            chk("R4 no window beyond last frame", 200'(v), 200'(0));
            return;
        end
        rr  = (k - 1) / 2;
        lag = rr * W + rr;
        r   = p / W;
        c   = p % W;
        stp = (p + lag < N) ? acc_t[f][p + lag] : acc_t[f][N - 1] + p + lag - (N - 1);
        chk("R8 window arrival cycle", 200'(ccnt), 200'(stp + 2));
        chk("R4 frame-start flag", 200'(s), 200'(p == 0));
        e = '0;
        for (int i = 0; i < k; i++) begin
            for (int j = 0; j < k; j++) begin
                y = bfold(r + i - rr, H, m);
                x = bfold(c + j - rr, W, m);
                e[(i*k + j)*8 +: 8] = (y < 0 || x < 0) ? FILLV : img[f][y][x];
            end
        end
        if (m == 0)      chk("R1/R5 window taps, fill policy", w, e);
        else if (m == 1) chk("R1/R6 window taps, replicate policy", w, e);
        else             chk("R1/R7 window taps, reflect policy", w, e);
        if (p == N - 1) begin
            ocnt[id] = 0;
            ofr[id]  = f + 1;
        end else begin
            ocnt[id] = p + 1;
        end
    endtask

    always @(posedge clk) begin
        if (ce) ccnt <= ccnt + 1;
        lce <= ce;
    end

    always @(negedge clk) begin
        if (rst_n && lce && mon_en) begin
            obs(0, 3, 0, vo[0], so[0], {128'b0, w0});
            obs(1, 3, 1, vo[1], so[1], {128'b0, w1});
            obs(2, 3, 2, vo[2], so[2], {128'b0, w2});
            obs(3, 5, 2, vo[3], so[3], w3);
        end
    end

    task automatic send_frame(input int f, input int gap, input int cel, input bit record);
        int idx;
        idx = 0;
        while (idx < N) begin
            @(negedge clk); #1;
            ce  = (int'($urandom % 100) < cel) ? 1'b0 : 1'b1;
            vin = 1'b0;
            sof = 1'b0;
            #1;
            if (!ce) chk("R9 ready low while clock enable low", 200'(rdy), 200'(0));
            else if (rdy == 4'hF && int'($urandom % 100) >= gap) begin
                vin = 1'b1;
                sof = (idx == 0);
                din = img[f][idx / W][idx % W];
                if (record) acc_t[f][idx] = ccnt;
                idx++;
            end
        end
        @(negedge clk); #1;
        vin = 1'b0; sof = 1'b0; ce = 1'b1;
        #1;
        chk("R9 ready low after last pixel of frame", 200'(rdy), 200'(0));
    endtask

    task automatic drain(input bit bogus);
        forever begin
            @(negedge clk); #2;
            if (rdy == 4'hF) begin
                vin = 1'b0; sof = 1'b0;
                break;
            end
            // R2, R3: offered data while ready is low must not be taken, marker included
            if (bogus && rdy == 4'h0) begin
                vin = 1'b1; sof = 1'b1; din = 8'hFF;
            end else begin
                vin = 1'b0; sof = 1'b0;
            end
        end
    endtask

    initial begin
        for (int f = 0; f < 3; f++)
            for (int y = 0; y < H; y++)
                for (int x = 0; x < W; x++)
                    img[f][y][x] = (f == 1) ? 8'(y * 16 + x) : 8'($urandom);
        for (int i = 0; i < 4; i++) begin ocnt[i] = 0; ofr[i] = 0; end
        rst_n = 1'b0; srst = 1'b0; ce = 1'b1; vin = 1'b0; sof = 1'b0; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk("R11 reset state ready", 200'(rdy), 200'(4'hF));
        chk("R11 reset state no window", 200'(vo), 200'(0));

        // R3: pixels before a start-of-frame marker leave the counters off zero
        for (int n = 0; n < 5; n++) begin
            @(negedge clk); #1; vin = 1'b1; sof = 1'b0; din = 8'h3C;
        end
        @(negedge clk); #1; vin = 1'b0;

        send_frame(0, 0, 0, 1'b1);
        drain(1'b0);
        send_frame(1, 40, 0, 1'b1);
        drain(1'b1);
        send_frame(2, 30, 15, 1'b1);
        drain(1'b0);
        repeat (10) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            chk("R4 window count per frame", 200'(ocnt[i]), 200'(0));
            chk("R4 frames completed", 200'(ofr[i]), 200'(3));
        end

        // R11: synchronous reset in the middle of end-of-frame production
        mon_en = 1'b0;
        send_frame(0, 0, 0, 1'b0);
        @(negedge clk); #1; srst = 1'b1;
        @(negedge clk); #1; srst = 1'b0; #1;
        chk("R11 ready after sync reset", 200'(rdy), 200'(4'hF));
        chk("R11 no window after sync reset", 200'(vo), 200'(0));
        repeat (3) @(negedge clk);
        chk("R11 idle stays idle", 200'(vo), 200'(0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule